// File: doc/BRIEF.md
# Posted Write Bus Master Forwarder

This block sits on the target-bus side of a two-port bridge. It drains a posted-write queue that another block fills. Each queue entry is either a burst header carrying the start address or a data word with a flag that marks the burst's final word. The block replays each burst as a master on a simplified parallel bus with active-low request, grant, frame, initiator-ready, target-ready, stop and device-select signals, plus a 32-bit multiplexed address/data path.

Forwarding does not wait for the whole burst to be queued. The block asks for the bus as soon as a header reaches the queue head. It streams one word per clock while words keep arriving. If the queue runs dry before the flagged word, it closes the transaction with that word and later opens a follow-on transaction at the next sequential address. A target disconnect ends the transaction in the same way, and the burst resumes at the first word the target did not accept. If no target claims the transaction in time, the block aborts it and discards the rest of that burst from the queue.

Top module: `pw_fwd_master`

## Requirements
- R1: When a header entry (hd_is_hdr=1) is at the queue head in the idle state, it is popped and req_n goes low on the next clock. req_n stays low until the address phase starts, even if no data word has arrived yet.
- R2: An address phase (frame_n low, irdy_n high, ad_oe high, ad_out = current word address with bits 1:0 cleared) follows a cycle in which the bus was requested, gnt_n was low, bus_frame_n and bus_irdy_n were both high, and a data word was at the head.
- R3: The clock after the address phase is the first data phase. irdy_n is low in every data phase, and ad_out carries the head data word.
- R4: A word is popped exactly when trdy_n is low in a data phase. After a non-final accepted word, the next clock is again a data phase, so the master inserts no wait states. Successive accepted words go to addresses that rise by 4.
- R5: frame_n is high in a data phase whose word has hd_last=1, or when no second entry is queued behind it (nx_valid=0). Once it is high in a transaction it stays high until that transaction ends, including across target wait states.
- R6: When a non-flagged final-phase word is accepted, the bus is released. When the next word of the same burst reaches the head, the block requests again and its address phase carries the address following the last accepted word.
- R7: stop_n low in a data phase ends the transaction after that clock. A word accepted with trdy_n in that same clock counts as delivered. The burst then resumes with a new request at the first undelivered address.
- R8: If device-select has not been seen by the fifth data-phase clock after the address phase, the block releases the bus without delivering anything further. It then pops and drops every remaining word of that burst up to and including the flagged word.
- R9: During and right after reset, req_n, frame_n and irdy_n are high, ad_oe is low, and no entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_valid | input | 1 | Queue head holds an entry |
| hd_is_hdr | input | 1 | Head entry is a burst header (address) |
| hd_last | input | 1 | Head data word is the last of its burst |
| hd_word | input | BUS_W | Head entry payload (address or data) |
| nx_valid | input | 1 | A second entry is queued behind the head |
| hd_pop | output | 1 | Remove head entry at this clock edge |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| bus_frame_n | input | 1 | Frame as driven by other masters |
| bus_irdy_n | input | 1 | Initiator-ready as driven by other masters |
| frame_n | output | 1 | Frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| ad_out | output | BUS_W | Address/data drive value |
| ad_oe | output | 1 | Address/data output enable |
| devsel_n | input | 1 | Target device select, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |

## Verification
The embedded properties check, every clock, that frame never re-asserts within a transaction once dropped, that an address phase is always followed by a data phase and was preceded by a grant on an idle bus, that a non-final accepted word leads to another data phase, and that no pop happens on an empty head. The sequences across transactions can only be shown by the bench scenarios. These are resuming after a dry queue or a disconnect at the right address, discarding the rest of an aborted burst, and the exact order and addresses of words the target receives. In those scenarios a cycle-level reference model is compared with the outputs, and a target model logs each accepted word.

// File: rtl/pw_fwd_master.sv
module pw_fwd_master #(
  parameter int BUS_W        = 32,
  parameter int DEVSEL_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd_valid,
  input  logic             hd_is_hdr,
  input  logic             hd_last,
  input  logic [BUS_W-1:0] hd_word,
  input  logic             nx_valid,
  output logic             hd_pop,
  output logic             req_n,
  input  logic             gnt_n,
  input  logic             bus_frame_n,
  input  logic             bus_irdy_n,
  output logic             frame_n,
  output logic             irdy_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  input  logic             devsel_n,
  input  logic             trdy_n,
  input  logic             stop_n
);
  localparam int CW = $clog2(DEVSEL_LIMIT + 1);

  typedef enum logic [2:0] {IDLE, ASK, ADR, XFER, REST, DROP} st_t;

  st_t             st;
  logic [BUS_W-1:0] addr;
  logic            fin;
  logic            seen;
  logic [CW-1:0]   age;

  wire in_data  = (st == XFER);
  wire xfer     = in_data && !trdy_n;
  wire final_ph = fin || hd_last || !nx_valid;
  wire seen_now = seen || !devsel_n;
  wire timeout  = !seen_now && (age == CW'(DEVSEL_LIMIT));
  wire start    = (st == ASK) && !gnt_n && bus_frame_n && bus_irdy_n && hd_valid;

  assign hd_pop  = ((st == IDLE) && hd_valid && hd_is_hdr) || xfer ||
                   ((st == DROP) && hd_valid && !hd_is_hdr);
  assign req_n   = (st != ASK);
  assign frame_n = !((st == ADR) || (in_data && !final_ph));
  assign irdy_n  = !in_data;
  assign ad_oe   = (st == ADR) || in_data;
  assign ad_out  = (st == ADR) ? addr : (in_data ? hd_word : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      addr <= '0;
      fin  <= 1'b0;
      seen <= 1'b0;
      age  <= '0;
    end else begin
      case (st)
        IDLE: if (hd_valid && hd_is_hdr) begin
          addr <= {hd_word[BUS_W-1:2], 2'b00};
          st   <= ASK;
        end
        ASK: if (start) st <= ADR;
        ADR: begin
          st   <= XFER;
          fin  <= 1'b0;
          seen <= 1'b0;
          age  <= CW'(1);
        end
        XFER: begin
          if (xfer) addr <= addr + BUS_W'(4);
          if (xfer && hd_last)        st <= IDLE;
          else if (xfer && final_ph)  st <= REST;
          else if (!stop_n)           st <= REST;
          else if (timeout)           st <= DROP;
          else begin
            fin  <= final_ph;
            seen <= seen_now;
            if (age != CW'(DEVSEL_LIMIT)) age <= age + CW'(1);
          end
        end
        REST: if (hd_valid) st <= ASK;
        DROP: if (hd_valid && !hd_is_hdr && hd_last) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assert_frame_stays_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && frame_n) |=> (frame_n || irdy_n));

  assert_data_follows_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && irdy_n) |=> !irdy_n);

  assert_addr_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && irdy_n) |-> $past(!gnt_n && bus_frame_n && bus_irdy_n));

  assert_no_master_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !frame_n && !trdy_n && !devsel_n && stop_n) |=> !irdy_n);

  assert_pop_needs_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hd_pop |-> hd_valid);
endmodule

// File: tb/pw_fwd_master_tb.sv
`timescale 1ns/1ps
module pw_fwd_master_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, hd_valid, hd_is_hdr, hd_last, nx_valid, hd_pop;
  logic [31:0] hd_word, ad_out;
  logic req_n, gnt_n, bus_frame_n, bus_irdy_n, frame_n, irdy_n, ad_oe;
  logic devsel_n, trdy_n, stop_n;

  pw_fwd_master u_dut (
    .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_is_hdr(hd_is_hdr),
    .hd_last(hd_last), .hd_word(hd_word), .nx_valid(nx_valid), .hd_pop(hd_pop),
    .req_n(req_n), .gnt_n(gnt_n), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n));

  typedef struct packed { logic hdr; logic last; logic [31:0] d; } ent_t;
  typedef struct packed { logic [31:0] a; logic [31:0] d; } xf_t;

  ent_t fifo[$];
  ent_t pend[$];
  int   pend_t[$];
  xf_t  tlog[$];
  xf_t  elog[$];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int dev_at = 1, wmod = 0, stop_at = 0;
  logic gnt_v = 1'b0, busy = 1'b0;

  int ph = 0, sent = 0, age = 0;
  logic [31:0] base = 0;
  bit mfin = 0, mseen = 0;

  bit t_act = 0;
  int tcyc = 0, txn = 0;
  logic [31:0] taddr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic hdr, input logic last, input logic [31:0] d, input int rel);
    pend.push_back('{hdr: hdr, last: last, d: d});
    pend_t.push_back(cyc + rel);
  endtask

  task automatic burst(input logic [31:0] a, input int n, input int rel_first, input int split, input int rel_rest);
    for (int i = 0; i < n; i++) begin
      logic [31:0] wa;
      wa = a + 32'(4 * i);
      put(1'b0, i == n - 1, {16'hDA7A, wa[15:0]}, (i < split) ? rel_first : rel_rest);
    end
  endtask

  task automatic expect_words(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] wa;
      wa = a + 32'(4 * i);
      elog.push_back('{a: wa, d: {16'hDA7A, wa[15:0]}});
    end
  endtask

  task automatic step();
    ent_t hd;
    bit hv, fn, dv, tr, sp, x, epop, efl;
    logic s_fr, s_ir;
    logic [31:0] s_ad, e_ad;
    int tmp;
    @(negedge clk);
    cyc++;
    while (pend.size() > 0 && pend_t[0] <= cyc) begin
      fifo.push_back(pend.pop_front());
      tmp = pend_t.pop_front();
    end
    hv = fifo.size() > 0;
    hd = hv ? fifo[0] : '0;
    hd_valid = hv; hd_is_hdr = hd.hdr; hd_last = hd.last; hd_word = hd.d;
    nx_valid = fifo.size() > 1;
    gnt_n = gnt_v; bus_frame_n = !busy; bus_irdy_n = !busy;
    dv = t_act && tcyc >= dev_at;
    tr = dv && !(wmod > 0 && (tcyc % wmod) == 0);
    sp = tr && stop_at > 0 && (txn + 1) == stop_at;
    devsel_n = !dv; trdy_n = !tr; stop_n = !sp;
    #1;
    fn   = mfin || hd.last || fifo.size() < 2;
    x    = (ph == 3) && tr;
    epop = (ph == 0 && hv && hd.hdr) || x || (ph == 5 && hv && !hd.hdr);
    efl  = (ph == 2) || (ph == 3 && !fn);
    e_ad = (ph == 2) ? base + 32'(4 * sent) : hd.d;
    chk(req_n == !(ph == 1), "R1 req_n", 32'(req_n), 32'(!(ph == 1)));
    chk(frame_n == !efl, "R5 frame_n", 32'(frame_n), 32'(!efl));
    chk(irdy_n == !(ph == 3), "R3 irdy_n", 32'(irdy_n), 32'(!(ph == 3)));
    chk(ad_oe == (ph == 2 || ph == 3), "R2 ad_oe", 32'(ad_oe), 32'(ph == 2 || ph == 3));
    chk(hd_pop == epop, "R4 hd_pop", 32'(hd_pop), 32'(epop));
    if (ph == 2 || ph == 3) chk(ad_out == e_ad, "R2 ad_out", ad_out, e_ad);
    s_fr = frame_n; s_ir = irdy_n; s_ad = ad_out;
    @(posedge clk);
    case (ph)
      0: if (hv && hd.hdr) begin base = {hd.d[31:2], 2'b00}; sent = 0; ph = 1; end
      1: if (!gnt_v && !busy && hv) ph = 2;
      2: begin ph = 3; mfin = 0; mseen = 0; age = 1; end
      3: begin
        if (x) sent++;
        if (x && hd.last) ph = 0;
        else if (x && fn) ph = 4;
        else if (sp) ph = 4;
        else if (!(mseen || dv) && age == 5) ph = 5;
        else begin mfin = fn; mseen = mseen || dv; if (age < 5) age++; end
      end
      4: if (hv) ph = 1;
      5: if (hv && !hd.hdr && hd.last) ph = 0;
      default: ph = 0;
    endcase
    if (epop && hv) void'(fifo.pop_front());
    if (!s_fr && s_ir) begin
      t_act = 1; tcyc = 1; txn = 0; taddr = s_ad;
    end else if (t_act) begin
      if (s_ir) t_act = 0;
      else begin
        if (tr) begin tlog.push_back('{a: taddr, d: s_ad}); taddr += 4; txn++; end
        if ((tr && s_fr) || sp) t_act = 0;
        tcyc++;
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic close_scn(input string tag);
    chk(tlog.size() == elog.size(), {tag, " word count"}, 32'(tlog.size()), 32'(elog.size()));
    for (int i = 0; i < tlog.size() && i < elog.size(); i++) begin
      chk(tlog[i].a == elog[i].a, {tag, " address"}, tlog[i].a, elog[i].a);
      chk(tlog[i].d == elog[i].d, {tag, " data"}, tlog[i].d, elog[i].d);
    end
    chk(fifo.size() == 0, {tag, " queue drained"}, 32'(fifo.size()), 0);
    tlog.delete(); elog.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; hd_valid = 0; hd_is_hdr = 0; hd_last = 0; hd_word = 0; nx_valid = 0;
    gnt_n = 1; bus_frame_n = 1; bus_irdy_n = 1; devsel_n = 1; trdy_n = 1; stop_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(req_n && frame_n && irdy_n && !ad_oe && !hd_pop, "R9 reset outputs",
        {27'b0, req_n, frame_n, irdy_n, ad_oe, hd_pop}, 32'b11100);
    rst_n = 1;

    // R4 R5: full burst already queued, fast target
    put(1'b1, 1'b0, 32'h0000_0100, 0);
    burst(32'h100, 4, 0, 4, 0);
    expect_words(32'h100, 4);
    run(20);
    close_scn("R4 streamed burst");

    // R1 R6: header before data, queue runs dry mid-burst
    put(1'b1, 1'b0, 32'h0000_0202, 0);
    burst(32'h200, 5, 5, 2, 16);
    run(3);
    #1;
    chk(!req_n && irdy_n, "R1 request before data", {30'b0, req_n, irdy_n}, 32'b01);
    expect_words(32'h200, 5);
    run(40);
    close_scn("R6 follow-on after dry queue");

    // R7: target disconnect every second word
    stop_at = 2;
    put(1'b1, 1'b0, 32'h0000_0300, 0);
    burst(32'h300, 6, 0, 6, 0);
    expect_words(32'h300, 6);
    run(40);
    close_scn("R7 resume after disconnect");
    stop_at = 0;

    // R2 R3 R5: busy bus, late grant, slow target with waits
    gnt_v = 1; busy = 1; wmod = 3; dev_at = 3;
    put(1'b1, 1'b0, 32'h0000_0400, 0);
    burst(32'h400, 3, 0, 3, 0);
    run(6);
    busy = 0;
    run(2);
    #1;
    chk(!req_n && frame_n, "R2 waits for grant", {30'b0, req_n, frame_n}, 32'b01);
    gnt_v = 0;
    expect_words(32'h400, 3);
    run(30);
    close_scn("R2 granted burst");
    wmod = 0; dev_at = 1;

    // R8: no target claims; rest of burst dropped, next burst unaffected
    dev_at = 99;
    put(1'b1, 1'b0, 32'h0000_0500, 0);
    burst(32'h500, 4, 0, 2, 15);
    run(25);
    close_scn("R8 master abort");
    dev_at = 1;
    put(1'b1, 1'b0, 32'h0000_0600, 0);
    burst(32'h600, 2, 0, 2, 0);
    expect_words(32'h600, 2);
    run(20);
    close_scn("R8 burst after abort");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule